// File: doc/BRIEF.md
# Segment Selector Load Privilege Checker

This block decides whether a selector may be placed into one of eight segment or system registers. For each request it takes the code of the destination register, the two requested-privilege bits of the selector, the current privilege level, and three fields of the already-fetched descriptor: its privilege level, its S bit and its 4-bit type. It also takes a flag that marks a null selector. One clock later it returns a verdict: either allow or fault. A fault carries a cause code. An allowed load also raises one write-enable bit, and that bit selects the destination register.

There are four privilege levels, 0 to 3, and a smaller number carries more privilege. Each destination register has its own rule set. The four data registers require the descriptor level to be at or below the privilege of both the caller and the selector, which is a max-of-levels test. The code and stack registers demand an exact match with the current level. The two system-table registers accept only their own kind of system descriptor. When a request breaks more than one rule, a fixed priority picks the reported cause. A faulting request never raises a write enable, so the destination register keeps its old contents.

Top module: `seg_load_check`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid`, `rsp_allow`, `rsp_fault` and `load_en` are 0 and `rsp_cause` is 0.
- R2: A request sampled with `req_valid`=1 produces `rsp_valid`=1 on the next clock, with exactly one of `rsp_allow` or `rsp_fault` set. A cycle with no request is followed by `rsp_valid`, `rsp_allow` and `rsp_fault` all 0.
- R3: Target codes are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS, 6=LDTR and 7=TR. A non-null request to ES, DS, FS, GS, CS or SS whose `desc_s`=0 faults with cause 2 (system descriptor).
- R4: For ES, DS, FS and GS with `desc_s`=1 and an acceptable type, the load is allowed only if `desc_dpl` >= max(`cur_pl`, `sel_rpl`). Otherwise it faults with cause 4 (privilege).
- R5: With `desc_s`=1, type bit 3 set marks a code segment and bit 3 clear marks a data segment. Bit 1 means readable for code and writable for data. ES, DS, FS and GS accept any data segment, and accept code only if bit 1 is set. A code segment with bit 1 clear faults with cause 3 (type).
- R6: CS accepts only a code segment. A data segment faults with cause 3. A code segment with `desc_dpl` != `cur_pl` faults with cause 4, and `sel_rpl` has no effect on this check.
- R7: SS accepts only a writable data segment, and faults with cause 3 otherwise. The segment must also have `desc_dpl` == `cur_pl`, and faults with cause 4 otherwise.
- R8: LDTR accepts only `desc_s`=0 with type 4'h2. TR accepts only `desc_s`=0 with type 4'h1 or 4'h9. Any other descriptor faults with cause 3. No privilege test applies to these two targets.
- R9: When `req_null`=1, a load to CS, SS, LDTR or TR faults with cause 1. A load to ES, DS, FS or GS is allowed whatever the other fields hold.
- R10: `load_en` has bit [target code] set on an allowed response and no other bit set. On a fault, `load_en` is all zero.
- R11: When a request breaks more than one rule, the reported cause follows the priority null (1) > system (2) > type (3) > privilege (4). An allowed response reports cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_tgt | input | 3 | Destination register code |
| req_null | input | 1 | Selector is null |
| sel_rpl | input | 2 | Requested privilege level (selector low bits) |
| cur_pl | input | 2 | Current privilege level |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_s | input | 1 | Descriptor S bit (1 = code/data, 0 = system) |
| desc_type | input | 4 | Descriptor type field |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Load permitted |
| rsp_fault | output | 1 | Load rejected |
| rsp_cause | output | 3 | Fault cause (0 when allowed) |
| load_en | output | 8 | One-hot write enable for the destination register |

## Verification
The verdict is computed in a single combinational pass and captured in one register stage, so any decode error shows up as a wrong output in the cycle right after the request. A fault in the type decode or the privilege compare appears as a wrong allow or cause on that same response. A stale or corrupted output register shows as `rsp_valid` or `load_en` lingering into the following idle cycle. A swapped target decode shows as a `load_en` bit that does not match the target code, or as a rule set applied to the wrong register. Priority mistakes appear only when several rules fail together, so the stimulus deliberately combines null, system, type and privilege violations.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int NUM_TGT = 8;
  localparam int TGT_W   = $clog2(NUM_TGT);
  localparam int CAUSE_W = 3;

  typedef enum logic [TGT_W-1:0] {
    TGT_ES   = 3'd0,
    TGT_CS   = 3'd1,
    TGT_SS   = 3'd2,
    TGT_DS   = 3'd3,
    TGT_FS   = 3'd4,
    TGT_GS   = 3'd5,
    TGT_LDTR = 3'd6,
    TGT_TR   = 3'd7
  } tgt_e;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE = 3'd0,
    CZ_NULL = 3'd1,
    CZ_SYS  = 3'd2,
    CZ_TYPE = 3'd3,
    CZ_PRIV = 3'd4
  } cause_e;

  typedef struct packed {
    logic is_code;
    logic is_data;
    logic code_rd;
    logic data_wr;
    logic is_ldt;
    logic is_tss;
  } desc_cls_t;
endpackage

// File: rtl/seg_desc_class.sv
module seg_desc_class
  import seg_chk_pkg::*;
#(
  parameter int TYPE_W = 4
) (
  input  logic              desc_s,
  input  logic [TYPE_W-1:0] desc_type,
  output desc_cls_t         cls
);
  localparam logic [TYPE_W-1:0] LDT_CODE  = TYPE_W'(2);
  localparam logic [TYPE_W-1:0] TSS_NARROW = TYPE_W'(1);
  localparam logic [TYPE_W-1:0] TSS_WIDE   = TYPE_W'(9);
  localparam int EXEC_BIT = TYPE_W - 1;
  localparam int RW_BIT   = 1;

  always_comb begin
    cls.is_code = desc_s & desc_type[EXEC_BIT];
    cls.is_data = desc_s & ~desc_type[EXEC_BIT];
    cls.code_rd = cls.is_code & desc_type[RW_BIT];
    cls.data_wr = cls.is_data & desc_type[RW_BIT];
    cls.is_ldt  = ~desc_s & (desc_type == LDT_CODE);
    cls.is_tss  = ~desc_s & ((desc_type == TSS_NARROW) || (desc_type == TSS_WIDE));
  end
endmodule

// File: rtl/seg_priv_cmp.sv
module seg_priv_cmp #(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] sel_rpl,
  input  logic [PL_W-1:0] cur_pl,
  input  logic [PL_W-1:0] desc_dpl,
  output logic            weak_ok,
  output logic            exact_ok
);
  logic [PL_W-1:0] least_priv;

  always_comb begin
    least_priv = (cur_pl > sel_rpl) ? cur_pl : sel_rpl;
    weak_ok    = (desc_dpl >= least_priv);
    exact_ok   = (desc_dpl == cur_pl);
  end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_chk_pkg::*;
(
  input  tgt_e      tgt,
  input  logic      is_null,
  input  logic      desc_s,
  input  desc_cls_t cls,
  input  logic      weak_ok,
  input  logic      exact_ok,
  output cause_e    cause
);
  always_comb begin
    cause = CZ_NONE;
    case (tgt)
      TGT_ES, TGT_DS, TGT_FS, TGT_GS: begin
        if (is_null)                            cause = CZ_NONE;
        else if (!desc_s)                       cause = CZ_SYS;
        else if (!(cls.is_data || cls.code_rd)) cause = CZ_TYPE;
        else if (!weak_ok)                      cause = CZ_PRIV;
      end
      TGT_CS: begin
        if (is_null)           cause = CZ_NULL;
        else if (!desc_s)      cause = CZ_SYS;
        else if (!cls.is_code) cause = CZ_TYPE;
        else if (!exact_ok)    cause = CZ_PRIV;
      end
      TGT_SS: begin
        if (is_null)           cause = CZ_NULL;
        else if (!desc_s)      cause = CZ_SYS;
        else if (!cls.data_wr) cause = CZ_TYPE;
        else if (!exact_ok)    cause = CZ_PRIV;
      end
      TGT_LDTR: begin
        if (is_null)          cause = CZ_NULL;
        else if (!cls.is_ldt) cause = CZ_TYPE;
      end
      TGT_TR: begin
        if (is_null)          cause = CZ_NULL;
        else if (!cls.is_tss) cause = CZ_TYPE;
      end
      default: cause = CZ_TYPE;
    endcase
  end
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
  import seg_chk_pkg::*;
#(
  parameter int PL_W   = 2,
  parameter int TYPE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [TGT_W-1:0]   req_tgt,
  input  logic               req_null,
  input  logic [PL_W-1:0]    sel_rpl,
  input  logic [PL_W-1:0]    cur_pl,
  input  logic [PL_W-1:0]    desc_dpl,
  input  logic               desc_s,
  input  logic [TYPE_W-1:0]  desc_type,
  output logic               rsp_valid,
  output logic               rsp_allow,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [NUM_TGT-1:0] load_en
);
  desc_cls_t          cls;
  logic               weak_ok;
  logic               exact_ok;
  cause_e             cause_d;
  logic               ok_d;
  logic [NUM_TGT-1:0] load_d;

  seg_desc_class #(.TYPE_W(TYPE_W)) u_cls (
    .desc_s    (desc_s),
    .desc_type (desc_type),
    .cls       (cls)
  );

  seg_priv_cmp #(.PL_W(PL_W)) u_priv (
    .sel_rpl  (sel_rpl),
    .cur_pl   (cur_pl),
    .desc_dpl (desc_dpl),
    .weak_ok  (weak_ok),
    .exact_ok (exact_ok)
  );

  seg_rule_eval u_rule (
    .tgt      (tgt_e'(req_tgt)),
    .is_null  (req_null),
    .desc_s   (desc_s),
    .cls      (cls),
    .weak_ok  (weak_ok),
    .exact_ok (exact_ok),
    .cause    (cause_d)
  );

  assign ok_d = (cause_d == CZ_NONE);

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_wen
    assign load_d[i] = req_valid && ok_d && (req_tgt == TGT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      load_en   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && ok_d;
      rsp_fault <= req_valid && !ok_d;
      rsp_cause <= req_valid ? cause_d : CZ_NONE;
      load_en   <= load_d;
    end
  end
endmodule

// File: rtl/seg_load_check_sva.sv
module seg_load_check_sva (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_tgt,
  input logic       req_null,
  input logic [1:0] cur_pl,
  input logic [1:0] desc_dpl,
  input logic       desc_s,
  input logic       rsp_valid,
  input logic       rsp_allow,
  input logic       rsp_fault,
  input logic [2:0] rsp_cause,
  input logic [7:0] load_en
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid && (rsp_allow != rsp_fault)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_allow && !rsp_fault); // R2
  AST_WEN_ONLY_ALLOW: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> load_en == 8'h00); // R10
  AST_WEN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> $countones(load_en) == 1); // R10
  AST_SYS_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_null && !desc_s && req_tgt <= 3'd5) |=>
      rsp_fault && rsp_cause == 3'd2); // R3
  AST_CS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_tgt == 3'd1 && desc_dpl != cur_pl) |=> rsp_fault); // R6
  AST_SS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_tgt == 3'd2 && desc_dpl != cur_pl) |=> rsp_fault); // R7
  AST_NULL_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_null && (req_tgt == 3'd1 || req_tgt == 3'd2 || req_tgt >= 3'd6)) |=>
      rsp_fault && rsp_cause == 3'd1); // R9
  AST_ALLOW_CAUSE0: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> rsp_cause == 3'd0); // R11
endmodule

bind seg_load_check seg_load_check_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_tgt   (req_tgt),
  .req_null  (req_null),
  .cur_pl    (cur_pl),
  .desc_dpl  (desc_dpl),
  .desc_s    (desc_s),
  .rsp_valid (rsp_valid),
  .rsp_allow (rsp_allow),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .load_en   (load_en)
);

// File: tb/sim_seg_load_check.sv
module sim_seg_load_check;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RANDOM   = 3000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_tgt = '0;
  logic       req_null = 1'b0;
  logic [1:0] sel_rpl = '0;
  logic [1:0] cur_pl = '0;
  logic [1:0] desc_dpl = '0;
  logic       desc_s = 1'b0;
  logic [3:0] desc_type = '0;
  logic       rsp_valid;
  logic       rsp_allow;
  logic       rsp_fault;
  logic [2:0] rsp_cause;
  logic [7:0] load_en;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_load_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_tgt(req_tgt),
    .req_null(req_null), .sel_rpl(sel_rpl), .cur_pl(cur_pl),
    .desc_dpl(desc_dpl), .desc_s(desc_s), .desc_type(desc_type),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .load_en(load_en)
  );

  // Expected cause, written from the requirement text.
  function automatic logic [2:0] model(input logic [2:0] t, input logic nl,
                                       input logic [1:0] rp, input logic [1:0] cp,
                                       input logic [1:0] dp, input logic s,
                                       input logic [3:0] ty);
    logic code, rw, dataseg;
    logic [1:0] mx;
    code    = s && ty[3];
    dataseg = s && !ty[3];
    rw      = ty[1];
    mx      = (cp > rp) ? cp : rp;
    case (t)
      3'd0, 3'd3, 3'd4, 3'd5: begin
        if (nl) return 3'd0;
        if (!s) return 3'd2;
        if (!(dataseg || (code && rw))) return 3'd3;
        if (dp < mx) return 3'd4;
        return 3'd0;
      end
      3'd1: begin
        if (nl) return 3'd1;
        if (!s) return 3'd2;
        if (!code) return 3'd3;
        if (dp != cp) return 3'd4;
        return 3'd0;
      end
      3'd2: begin
        if (nl) return 3'd1;
        if (!s) return 3'd2;
        if (!(dataseg && rw)) return 3'd3;
        if (dp != cp) return 3'd4;
        return 3'd0;
      end
      3'd6: begin
        if (nl) return 3'd1;
        if (s || ty != 4'h2) return 3'd3;
        return 3'd0;
      end
      default: begin
        if (nl) return 3'd1;
        if (s || !(ty == 4'h1 || ty == 4'h9)) return 3'd3;
        return 3'd0;
      end
    endcase
  endfunction

  task automatic check_resp(input string tag, input logic [2:0] ec, input logic [2:0] t);
    logic [7:0] ew;
    logic ea;
    ea = (ec == 3'd0);
    ew = ea ? (8'h01 << t) : 8'h00;
    n_vec++;
    if (rsp_valid !== 1'b1 || rsp_allow !== ea || rsp_fault !== !ea ||
        rsp_cause !== ec || load_en !== ew) begin
      n_bad++;
      $display("FAIL %s tgt=%0d: v=%b a=%b f=%b cause=%0d wen=%h, expected v=1 a=%b f=%b cause=%0d wen=%h",
               tag, t, rsp_valid, rsp_allow, rsp_fault, rsp_cause, load_en,
               ea, !ea, ec, ew);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] t, input logic nl,
                       input logic [1:0] rp, input logic [1:0] cp, input logic [1:0] dp,
                       input logic s, input logic [3:0] ty);
    @(negedge clk);
    req_valid = 1'b1; req_tgt = t; req_null = nl; sel_rpl = rp;
    cur_pl = cp; desc_dpl = dp; desc_s = s; desc_type = ty;
    @(negedge clk);
    req_valid = 1'b0;
    check_resp(tag, model(t, nl, rp, cp, dp, s, ty), t);
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    @(negedge clk);
    n_vec++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_fault !== 1'b0 ||
        rsp_cause !== 3'd0 || load_en !== 8'h00) begin
      n_bad++;
      $display("FAIL %s idle: v=%b a=%b f=%b cause=%0d wen=%h, expected all 0",
               tag, rsp_valid, rsp_allow, rsp_fault, rsp_cause, load_en);
    end
  endtask

  function automatic string tag_of(input logic [2:0] t, input logic [2:0] c);
    if (c == 3'd1 || (c == 3'd0 && req_null)) return "R9";
    if (c == 3'd2) return "R3";
    if (t == 3'd1) return "R6";
    if (t == 3'd2) return "R7";
    if (t >= 3'd6) return "R8";
    if (c == 3'd3) return "R5";
    return "R4";
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7741);
    repeat (3) @(negedge clk);
    // R1: outputs held low during reset
    n_vec++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_fault !== 1'b0 ||
        rsp_cause !== 3'd0 || load_en !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: v=%b a=%b f=%b cause=%0d wen=%h, expected all 0",
               rsp_valid, rsp_allow, rsp_fault, rsp_cause, load_en);
    end
    rst = 1'b0;
    check_idle("R1");

    // Directed corner cases
    apply("R4", 3'd3, 0, 2'd1, 2'd2, 2'd2, 1, 4'h2);   // dpl == max: allow
    apply("R4", 3'd0, 0, 2'd3, 2'd0, 2'd2, 1, 4'h0);   // rpl dominates: priv fault
    apply("R4", 3'd5, 0, 2'd0, 2'd3, 2'd3, 1, 4'hA);   // readable code ok
    apply("R5", 3'd4, 0, 2'd0, 2'd0, 2'd3, 1, 4'h8);   // exec-only code: type
    apply("R3", 3'd2, 0, 2'd0, 2'd0, 2'd0, 0, 4'h2);   // system into SS
    apply("R3", 3'd1, 0, 2'd0, 2'd0, 2'd0, 0, 4'h9);   // system into CS
    apply("R6", 3'd1, 0, 2'd3, 2'd1, 2'd1, 1, 4'h8);   // rpl ignored: allow
    apply("R6", 3'd1, 0, 2'd0, 2'd0, 2'd0, 1, 4'h2);   // data into CS: type
    apply("R6", 3'd1, 0, 2'd0, 2'd0, 2'd1, 1, 4'hA);   // dpl != cpl: priv
    apply("R7", 3'd2, 0, 2'd0, 2'd2, 2'd2, 1, 4'h2);   // writable data: allow
    apply("R7", 3'd2, 0, 2'd0, 2'd2, 2'd2, 1, 4'h0);   // read-only: type
    apply("R7", 3'd2, 0, 2'd0, 2'd1, 2'd2, 1, 4'h3);   // dpl != cpl: priv
    apply("R8", 3'd6, 0, 2'd3, 2'd3, 2'd0, 0, 4'h2);   // LDT ok, no priv test
    apply("R8", 3'd6, 0, 2'd0, 2'd0, 2'd0, 0, 4'h9);   // TSS into LDTR: type
    apply("R8", 3'd7, 0, 2'd3, 2'd3, 2'd0, 0, 4'h9);   // TSS ok
    apply("R8", 3'd7, 0, 2'd0, 2'd0, 2'd0, 0, 4'h1);   // narrow TSS ok
    apply("R8", 3'd7, 0, 2'd0, 2'd0, 2'd0, 1, 4'h9);   // S=1: type
    apply("R9", 3'd3, 1, 2'd3, 2'd3, 2'd0, 0, 4'h0);   // null data reg: allow
    apply("R9", 3'd2, 1, 2'd0, 2'd0, 2'd0, 1, 4'h2);   // null SS: fault
    apply("R9", 3'd7, 1, 2'd0, 2'd0, 2'd0, 0, 4'h9);   // null TR: fault
    apply("R11", 3'd1, 1, 2'd0, 2'd0, 2'd3, 0, 4'h0);  // null beats system
    apply("R11", 3'd2, 0, 2'd0, 2'd0, 2'd3, 1, 4'h8);  // type beats privilege
    apply("R11", 3'd0, 0, 2'd3, 2'd3, 2'd0, 0, 4'h8);  // system beats privilege
    apply("R10", 3'd5, 0, 2'd0, 2'd0, 2'd0, 1, 4'h0);  // wen bit 5
    check_idle("R2");

    // Random vectors
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [2:0] t;
      logic nl, s;
      logic [1:0] rp, cp, dp;
      logic [3:0] ty;
      t  = 3'($urandom % 8);
      nl = (($urandom % 8) == 0);
      s  = (($urandom % 4) != 0);
      rp = 2'($urandom % 4);
      cp = 2'($urandom % 4);
      dp = 2'($urandom % 4);
      ty = 4'($urandom % 16);
      req_null = nl;
      apply(tag_of(t, model(t, nl, rp, cp, dp, s, ty)), t, nl, rp, cp, dp, s, ty);
      if ((i % 500) == 0) check_idle("R2");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL R2 watchdog: run did not complete, expected completion within %0d cycles", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule